// File: doc/BRIEF.md
# Software Stimulus Trace Port Unit

This unit lets firmware emit trace events by writing to memory-mapped stimulus registers. There are 32 stimulus ports, one 4-byte word each. A write of 8, 16 or 32 bits to an enabled port becomes a packet. The packet holds a header that names the port and the payload size, then the payload bytes. A 32-bit timestamp taken from an external cycle counter can follow the payload. Packets are queued as whole entries in a small FIFO. A framer then sends each entry out one byte at a time on a valid/ready stream to a downstream serializer.

Three configuration registers control which writes are accepted:
- a per-port enable mask;
- a privilege mask, in which each bit guards a group of eight ports against unprivileged writes;
- a control word that holds the global enable and the timestamp enable.

Before writing, firmware reads a stimulus port. A value of 1 means the write will be taken. A value of 0 means the write would be lost, either because tracing is off or because the FIFO is full. A write that reaches a full FIFO is dropped. The packet accepted next is then preceded by one overflow marker byte.

Top module: `swtrace_unit`

## Requirements
- R1: Stimulus port n is mapped at byte offset 4×n (port 31 at 0x07C). Each packet starts with the header byte {port[4:0], 1'b0, size_code[1:0]}, followed by the payload bytes, least-significant byte first.
- R2: The bus size code 00/01/10 (byte/half/word) gives a payload of 1/2/4 bytes, and size_code is 01/10/11 respectively. A stimulus write with size code 11 is dropped.
- R3: A stimulus write to a port whose bit is clear in the port-enable register (offset 0xE00, bit n = port n) produces no packet.
- R4: While the global enable (control register at offset 0xE80, bit 0) is clear, every stimulus write is dropped.
- R5: A read of a stimulus port returns 1 when the global enable is set, the port is enabled and the FIFO is not full. In every other case it returns 0.
- R6: When the timestamp enable (control bit 1) is set, four bytes of ts_count are appended after the payload, least-significant byte first. The value is the one sampled in the cycle of the write.
- R7: A stimulus write that would otherwise be accepted, but arrives while the FIFO is full, is dropped. The next accepted packet is preceded by exactly one byte 0x70, and later packets carry no marker.
- R8: The privilege register at offset 0xE40 holds one bit per group of eight ports (bit k covers ports 8k to 8k+7). When a group's bit is set, unprivileged stimulus writes to that group are dropped and privileged writes are accepted.
- R9: The port-enable, privilege and control registers read back what was written, in their implemented widths (32, 4 and 2 bits). All of them reset to zero.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the unit |
| bus_size | input | 2 | Write size: 00 byte, 01 half, 10 word |
| bus_priv | input | 1 | Access is privileged |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| ts_count | input | 32 | External cycle counter used as the timestamp |
| out_valid | output | 1 | A trace byte is offered |
| out_data | output | 8 | Trace byte |
| out_ready | input | 1 | The serializer takes the byte |

## Verification
The bench builds the unit with a FIFO depth of 4 entries, keeping the default of 32 ports and 4 privilege groups. With the shallow FIFO, the full condition, the dropped write and the single overflow marker are reached after only a few writes while the output is stalled. The port count and group count exercise the top port at offset 0x07C and a protected group in the middle of the map. The output handshake is driven by three patterns, stalled, free-running and alternating, so that stability under backpressure and per-byte sequencing are both covered.

// File: rtl/swtrace_pkg.sv
package swtrace_pkg;

  // One queued trace packet, held whole until the framer finishes sending it
  typedef struct packed {
    logic        ovf;        // emit the overflow marker before the header
    logic [4:0]  port;
    logic [1:0]  size_code;  // 1, 2 or 3 -> 1, 2 or 4 payload bytes
    logic [31:0] data;
    logic        has_ts;
    logic [31:0] ts;
  } trace_entry_t;

  localparam int unsigned ENTRY_W = $bits(trace_entry_t);

  localparam logic [7:0]  OVF_MARK   = 8'h70;
  localparam logic [11:0] OFS_ENABLE = 12'hE00;
  localparam logic [11:0] OFS_PRIV   = 12'hE40;
  localparam logic [11:0] OFS_CTRL   = 12'hE80;

endpackage

// File: rtl/swtrace_regs.sv
module swtrace_regs
  import swtrace_pkg::*;
#(
  parameter int unsigned NPORTS  = 32,
  parameter int unsigned NGROUPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [11:0]         bus_addr,
  input  logic [1:0]          bus_size,
  input  logic                bus_priv,
  input  logic [31:0]         bus_wdata,
  input  logic                fifo_full,
  output logic [31:0]         bus_rdata,
  output logic                wr_hit,
  output logic [4:0]          hit_port,
  output logic [NPORTS-1:0]   ter_q,
  output logic [NGROUPS-1:0]  tpr_q,
  output logic [1:0]          ctrl_q
);

  localparam int unsigned PORT_W = $clog2(NPORTS);
  localparam int unsigned GRP_W  = $clog2(NGROUPS);

  logic              stim_sel;
  logic [PORT_W-1:0] port;
  logic [GRP_W-1:0]  grp;
  logic              ter_we, tpr_we, ctrl_we;
  logic [NPORTS-1:0]  ter_d;
  logic [NGROUPS-1:0] tpr_d;
  logic [1:0]         ctrl_d;
  logic               port_live;

  // Address decode
  always_comb begin
    stim_sel  = bus_sel && (bus_addr[11:PORT_W+2] == '0) && (bus_addr[1:0] == 2'b00);
    port      = bus_addr[PORT_W+1:2];
    grp       = port[PORT_W-1 -: GRP_W];
    ter_we    = bus_sel && bus_wr && (bus_addr == OFS_ENABLE);
    tpr_we    = bus_sel && bus_wr && (bus_addr == OFS_PRIV);
    ctrl_we   = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    port_live = ctrl_q[0] && ter_q[port];
    wr_hit    = stim_sel && bus_wr && (bus_size != 2'b11) && port_live
                && (bus_priv || !tpr_q[grp]);
    hit_port  = 5'(port);
  end

  // Next state of the configuration registers
  always_comb begin
    ter_d  = ter_q;
    tpr_d  = tpr_q;
    ctrl_d = ctrl_q;
    if (ter_we)  ter_d  = bus_wdata[NPORTS-1:0];
    if (tpr_we)  tpr_d  = bus_wdata[NGROUPS-1:0];
    if (ctrl_we) ctrl_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ter_q  <= '0;
      tpr_q  <= '0;
      ctrl_q <= '0;
    end else begin
      ter_q  <= ter_d;
      tpr_q  <= tpr_d;
      ctrl_q <= ctrl_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (stim_sel)                      bus_rdata = {31'b0, port_live && !fifo_full};
      else if (bus_addr == OFS_ENABLE)   bus_rdata = 32'(ter_q);
      else if (bus_addr == OFS_PRIV)     bus_rdata = 32'(tpr_q);
      else if (bus_addr == OFS_CTRL)     bus_rdata = {30'b0, ctrl_q};
    end
  end

endmodule

// File: rtl/swtrace_fifo.sv
module swtrace_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    full    = (cnt_q == (AW+1)'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = do_push ? wptr_q + 1'b1 : wptr_q;
    rptr_d  = do_pop  ? rptr_q + 1'b1 : rptr_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    dout    = mem[rptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

endmodule

// File: rtl/swtrace_framer.sv
module swtrace_framer
  import swtrace_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  trace_entry_t head,
  input  logic         empty,
  input  logic         out_ready,
  output logic         pop,
  output logic         out_valid,
  output logic [7:0]   out_data
);

  logic [3:0] idx_q, idx_d;
  logic [3:0] nb, last_idx, rel;
  logic [1:0] dsel, tsel;
  logic       xfer;

  always_comb begin
    nb       = (head.size_code == 2'd3) ? 4'd4 : {2'b00, head.size_code};
    last_idx = {3'b000, head.ovf} + nb + (head.has_ts ? 4'd4 : 4'd0);
    rel      = idx_q - {3'b000, head.ovf};
    dsel     = rel[1:0] - 2'd1;
    tsel     = rel[1:0] - 2'd1 - nb[1:0];

    if (head.ovf && idx_q == 4'd0)  out_data = OVF_MARK;
    else if (rel == 4'd0)           out_data = {head.port, 1'b0, head.size_code};
    else if (rel <= nb)             out_data = head.data[{dsel, 3'b000} +: 8];
    else                            out_data = head.ts[{tsel, 3'b000} +: 8];

    out_valid = !empty;
    xfer      = out_valid && out_ready;
    pop       = xfer && (idx_q == last_idx);
    idx_d     = idx_q;
    if (pop)       idx_d = 4'd0;
    else if (xfer) idx_d = idx_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 4'd0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/swtrace_unit.sv
module swtrace_unit
  import swtrace_pkg::*;
#(
  parameter int unsigned NPORTS  = 32,
  parameter int unsigned NGROUPS = 4,
  parameter int unsigned DEPTH   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_priv,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] ts_count,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               wr_hit, push_en, fifo_full, fifo_empty, pop;
  logic [4:0]         hit_port;
  logic [NPORTS-1:0]  ter_q;
  logic [NGROUPS-1:0] tpr_q;
  logic [1:0]         ctrl_q;
  logic               ovf_q, ovf_d;
  trace_entry_t       new_entry, head;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  swtrace_regs #(.NPORTS(NPORTS), .NGROUPS(NGROUPS)) i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_priv  (bus_priv),
    .bus_wdata (bus_wdata),
    .fifo_full (fifo_full),
    .bus_rdata (bus_rdata),
    .wr_hit    (wr_hit),
    .hit_port  (hit_port),
    .ter_q     (ter_q),
    .tpr_q     (tpr_q),
    .ctrl_q    (ctrl_q)
  );

  // Packet build and overflow bookkeeping
  always_comb begin
    push_en             = wr_hit && !fifo_full;
    new_entry.ovf       = ovf_q;
    new_entry.port      = hit_port;
    new_entry.size_code = bus_size + 2'd1;
    new_entry.data      = bus_wdata;
    new_entry.has_ts    = ctrl_q[1];
    new_entry.ts        = ts_count;
    ovf_d = ovf_q;
    if (push_en)                   ovf_d = 1'b0;
    else if (wr_hit && fifo_full)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovf_q <= 1'b0;
    else            ovf_q <= ovf_d;
  end

  swtrace_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (push_en),
    .din   (new_entry),
    .pop   (pop),
    .dout  (head),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  swtrace_framer i_framer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .head      (head),
    .empty     (fifo_empty),
    .out_ready (out_ready),
    .pop       (pop),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/swtrace_checker.sv
module swtrace_checker #(
  parameter int unsigned NPORTS  = 32,
  parameter int unsigned NGROUPS = 4
) (
  input logic               clk,
  input logic               rst_int_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic               bus_priv,
  input logic [31:0]        bus_rdata,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data,
  input logic               push_en,
  input logic               wr_hit,
  input logic               fifo_full,
  input logic               ovf_q,
  input logic [1:0]         ctrl_q,
  input logic [NGROUPS-1:0] tpr_q
);

  localparam int unsigned PORT_W = $clog2(NPORTS);
  localparam int unsigned GRP_SH = $clog2(NPORTS / NGROUPS);

  logic stim_acc;
  logic [PORT_W-1:0] port_c;
  assign stim_acc = bus_sel && (bus_addr[11:PORT_W+2] == '0) && (bus_addr[1:0] == 2'b00);
  assign port_c   = bus_addr[PORT_W+1:2];

  // R4: global enable clear means nothing enters the queue
  p_off_drop_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctrl_q[0] |-> !push_en);

  // R7: a full queue takes nothing
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_full |-> !push_en);

  // R7: a write lost to a full queue arms the marker
  p_ovf_mark_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_hit && fifo_full) |=> ovf_q);

  // R5: a ready report implies tracing on and room available
  p_ready_read_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stim_acc && !bus_wr && bus_rdata[0]) |-> (ctrl_q[0] && !fifo_full));

  // R8: unprivileged writes to a guarded group are refused
  p_priv_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stim_acc && bus_wr && !bus_priv && tpr_q[int'(port_c) >> GRP_SH]) |-> !wr_hit);

  // R10: an offered byte holds under backpressure
  p_stable_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind swtrace_unit swtrace_checker #(.NPORTS(NPORTS), .NGROUPS(NGROUPS)) i_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_priv  (bus_priv),
  .bus_rdata (bus_rdata),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .push_en   (push_en),
  .wr_hit    (wr_hit),
  .fifo_full (fifo_full),
  .ovf_q     (ovf_q),
  .ctrl_q    (ctrl_q),
  .tpr_q     (tpr_q)
);

// File: tb/test_swtrace_unit.sv
module test_swtrace_unit;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_priv, out_ready;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata, ts_count;
  logic        out_valid;
  logic [7:0]  out_data;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;
  bit ovf_pending = 0;
  bit done = 0;

  logic [7:0] exp_b[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  swtrace_unit #(.NPORTS(32), .NGROUPS(4), .DEPTH(DEPTH)) i_swtrace_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_priv(bus_priv),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ts_count(ts_count),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Output handshake pattern
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1'b0;
        1: out_ready = 1'b1;
        default: out_ready = ~out_ready;
      endcase
    end
  end

  // Monitor: compare every accepted byte with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (exp_b.size() == 0) begin
          check(1'b0, "R3/R4 unexpected byte", {24'b0, out_data}, 32'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_b.pop_front();
          t = exp_tag.pop_front();
          check(out_data == e, t, {24'b0, out_data}, {24'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                           input bit priv, input logic [31:0] ts);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    bus_priv = priv; ts_count = ts;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = 2'b10;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  // mode 0: accepted; 1: silently dropped; 2: dropped on a full queue
  task automatic stim(input int port, input logic [1:0] sz, input logic [31:0] d, input bit priv,
                      input bit ts_on, input logic [31:0] ts, input int mode, input string tag);
    if (mode == 0) begin
      int n;
      logic [1:0] code;
      n    = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      code = (sz == 2'b00) ? 2'b01 : (sz == 2'b01) ? 2'b10 : 2'b11;
      if (ovf_pending) begin
        exp_b.push_back(8'h70); exp_tag.push_back("R7 overflow marker");
        ovf_pending = 0;
      end
      exp_b.push_back({port[4:0], 1'b0, code}); exp_tag.push_back({tag, " header"});
      for (int i = 0; i < n; i++) begin
        exp_b.push_back(d[8*i +: 8]); exp_tag.push_back({tag, " payload"});
      end
      if (ts_on) for (int i = 0; i < 4; i++) begin
        exp_b.push_back(ts[8*i +: 8]); exp_tag.push_back("R6 timestamp");
      end
    end else if (mode == 2) begin
      ovf_pending = 1;
    end
    bus_write(12'(port * 4), sz, d, priv, ts);
  endtask

  task automatic drain();
    int g = 0;
    while (exp_b.size() != 0 && g < 2000) begin @(posedge clk); g++; end
    repeat (6) @(posedge clk);
    check(exp_b.size() == 0, "R1 scoreboard drained", exp_b.size(), 0);
  endtask

  initial begin
    logic [31:0] rd;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_size = '0; bus_priv = 0;
    bus_wdata = '0; ts_count = '0;
    rst_n = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R9 reset values
    bus_read(12'hE00, rd); check(rd == 0, "R9 enable reset", rd, 0);
    bus_read(12'hE40, rd); check(rd == 0, "R9 privilege reset", rd, 0);
    bus_read(12'hE80, rd); check(rd == 0, "R9 control reset", rd, 0);
    bus_read(12'h000, rd); check(rd == 0, "R5 port read while off", rd, 0);
    check(out_valid == 0, "R10 no output after reset", out_valid, 0);

    // R4 global enable off
    rdy_mode = 1;
    bus_write(12'hE00, 2'b10, 32'hFFFF_FFFF, 1, 0);
    stim(0, 2'b10, 32'hDEAD_0001, 1, 0, 0, 1, "R4");
    drain();

    // R9 readback, R3 disabled port
    bus_write(12'hE00, 2'b10, 32'hFFFF_FFF7, 1, 0);
    bus_write(12'hE80, 2'b10, 32'h0000_0001, 1, 0);
    bus_read(12'hE00, rd); check(rd == 32'hFFFF_FFF7, "R9 enable readback", rd, 32'hFFFF_FFF7);
    bus_read(12'hE80, rd); check(rd == 32'h1, "R9 control readback", rd, 1);
    stim(3, 2'b00, 32'h0000_00AA, 1, 0, 0, 1, "R3");
    bus_read(12'h00C, rd); check(rd == 0, "R5 disabled port reads 0", rd, 0);
    bus_read(12'h000, rd); check(rd == 1, "R5 live port reads 1", rd, 1);
    drain();

    // R1 / R2 sizes and mapping
    stim(0, 2'b00, 32'h0000_0041, 1, 0, 0, 0, "R1 byte");
    stim(1, 2'b01, 32'h0000_BEEF, 1, 0, 0, 0, "R2 half");
    stim(31, 2'b10, 32'h1234_5678, 1, 0, 0, 0, "R1 port31 word");
    stim(2, 2'b11, 32'h5555_5555, 1, 0, 0, 1, "R2 size11");
    drain();

    // R6 timestamp, alternating ready
    rdy_mode = 2;
    bus_write(12'hE80, 2'b10, 32'h0000_0003, 1, 0);
    stim(5, 2'b10, 32'hCAFE_F00D, 1, 1, 32'hA1B2_C3D4, 0, "R6 word");
    stim(6, 2'b00, 32'h0000_0099, 1, 1, 32'h0102_0304, 0, "R6 byte");
    drain();

    // R8 privilege group 1 (ports 8..15)
    rdy_mode = 1;
    bus_write(12'hE80, 2'b10, 32'h0000_0001, 1, 0);
    bus_write(12'hE40, 2'b10, 32'h0000_0002, 1, 0);
    bus_read(12'hE40, rd); check(rd == 32'h2, "R9 privilege readback", rd, 2);
    stim(9, 2'b00, 32'h0000_0011, 0, 0, 0, 1, "R8 unpriv guarded");
    stim(9, 2'b00, 32'h0000_0022, 1, 0, 0, 0, "R8 priv guarded");
    stim(16, 2'b00, 32'h0000_0033, 0, 0, 0, 0, "R8 unpriv open");
    drain();

    // R10 stall
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    stim(2, 2'b00, 32'h0000_0077, 1, 0, 0, 0, "R10 stalled");
    repeat (2) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && out_data == 8'h11, "R10 hold under stall", {23'b0, out_valid, out_data}, 32'h111);
    end

    // R7 fill remaining entries, then overflow
    for (int i = 1; i < DEPTH; i++)
      stim(20 + i, 2'b01, 32'h0000_1000 + i, 1, 0, 0, 0, "R7 fill");
    bus_read(12'h000, rd); check(rd == 0, "R5 full reads 0", rd, 0);
    stim(4, 2'b00, 32'h0000_00EE, 1, 0, 0, 2, "R7 lost");
    rdy_mode = 1;
    drain();
    stim(7, 2'b00, 32'h0000_0066, 1, 0, 0, 0, "R7 after overflow");
    stim(8, 2'b00, 32'h0000_0067, 1, 0, 0, 0, "R7 no second marker");
    drain();

    done = 1;
    summary();
  end

endmodule